// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus (clock plus open-drain data, as used by I2C). It answers to one fixed 7-bit device address and gives a host single-byte access to an 8-bit register bank that sits beside it. Both bus lines are oversampled by the system clock, so the system clock must run several times faster than the bus bit rate; fast mode at 400 kbit/s is the intended ceiling.

A write goes: START, device address with the direction bit at 0, register address, one data byte, STOP. The slave acknowledges each of the three bytes and raises a one-cycle write strobe toward the register bank. A read first writes the register address, then sends a repeated START and the device address with the direction bit at 1. The slave then returns one byte, most significant bit first. The bank answers through a read data bus and a hit flag. If the hit flag is low, the slave sends 0xFF. The data line is never driven high: the block only pulls it low through an output enable.

Top module: `tws_reg_slave`

## Requirements
- R1: After a synchronous active-low reset the data line is released (`sda_oe` = 0) and neither register strobe is asserted.
- R2: A falling data line while the clock is high is a START. A rising data line while the clock is high is a STOP. Data changes while the clock is low are bit values.
- R3: The first byte after a START carries the device address in its upper seven bits, MSB first, followed by the direction bit (1 = read, 0 = write). With the address 7'b1001000 the slave pulls the data line low during the ninth clock.
- R4: With any other device address the slave does not acknowledge, raises no strobe and keeps the line released until the next START or STOP.
- R5: In a write, the byte after the device address is the register address and the next byte is the data. Both are acknowledged and exactly one `reg_wr_en` pulse presents them on `reg_addr` and `reg_wdata`.
- R6: Only one data byte is taken per write. Further bytes before the STOP are not acknowledged and cause no write.
- R7: After a repeated START with the read bit set, the slave acknowledges and pulses `reg_rd_en` once. It then returns the byte at the register address last written, MSB first.
- R8: When `reg_hit` is low during the read, the byte returned is 0xFF.
- R9: After the read byte the slave releases the line. A host not-acknowledge returns it to idle. A host acknowledge gets no further data: the line stays released.
- R10: A START in any state abandons the transfer and begins address reception. A STOP in any state abandons it and returns to idle. An abandoned write produces no strobe.
- R11: The slave changes `sda_oe` only after a falling clock, never while the clock stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| reg_wr_en | output | 1 | One-cycle write strobe to the register bank |
| reg_rd_en | output | 1 | One-cycle read strobe; read data is captured in this cycle |
| reg_addr | output | 8 | Register address held from the last register-address byte |
| reg_wdata | output | 8 | Write data, valid with `reg_wr_en` |
| reg_rdata | input | 8 | Register contents at `reg_addr`, combinational from the bank |
| reg_hit | input | 1 | High when `reg_addr` names a mapped register |

## Verification
A host model drives the bus with an open-drain wired-AND of host and slave, and a small bank of four mapped registers answers the strobes. The patterns are a plain write, a read of that same register, a read of an unmapped address, and a wrong device address. The read of the written register shows that address and data land in the right fields. The unmapped read separates the 0xFF substitution from real contents, and the wrong address separates matching from blanket acknowledging. Further sequences add an extra data byte, a STOP inside a byte, a START inside a data byte and a host acknowledge after the read byte. Each of these shows whether the byte counter and state really restart, and whether the line stays released where only the host should drive it.

// File: rtl/tws_pkg.sv
// Shared types for the two-wire register slave.
package tws_pkg;

    // Protocol states of the byte-level controller.
    typedef enum logic [3:0] {
        ST_IDLE,      // bus free or transfer over
        ST_DEV,       // shifting in device address + direction
        ST_DEV_ACK,   // acknowledging device address
        ST_REG,       // shifting in register address
        ST_REG_ACK,   // acknowledging register address
        ST_WDAT,      // shifting in write data
        ST_WDAT_ACK,  // acknowledging write data
        ST_RDAT,      // shifting out read data
        ST_RD_ACK,    // host acknowledge slot after read data
        ST_IGNORE     // released, waiting for START or STOP
    } tws_state_e;

endpackage

// File: rtl/tws_bus_sense.sv
// Bus sensing: synchronises the two bus lines into the system clock
// domain and reports clock edges plus START and STOP conditions.
// Assumes the system clock is well above the bus bit rate so that
// every bus phase lasts several system clocks.
module tws_bus_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_sync;
    logic [LAST:0] sda_sync;
    logic          scl_q;
    logic          sda_q;
    logic          scl_s;
    logic          sda_s;

    // Synchroniser chains; idle bus is high, so reset to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
        end else begin
            scl_sync <= {scl_sync[LAST-1:0], scl_i};
            sda_sync <= {sda_sync[LAST-1:0], sda_i};
        end
    end

    assign scl_s = scl_sync[LAST];
    assign sda_s = sda_sync[LAST];

    // One-cycle delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode.
    always_comb begin
        sda_lvl   = sda_s;
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/tws_proto_fsm.sv
// Protocol controller: bit counting, address match, acknowledge
// generation, register strobes and read-data shifting.
// Assumes bus events come from tws_bus_sense and that read data
// (rd_byte) is valid combinationally in the cycle rd strobe is raised.
module tws_proto_fsm
    import tws_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1001000,
    parameter int         BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic              rd_stb,
    output logic [BYTE_W-1:0] reg_ptr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int              CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    tws_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] rx_byte;
    logic              ack_hold;
    logic              rd_mode;

    // Byte as it stands once the current sampled bit is shifted in.
    assign rx_byte = {rx_sh[BYTE_W-2:0], sda_lvl};

    // Main protocol sequencer; STOP and START override every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            ack_hold <= 1'b0;
            rd_mode  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            reg_ptr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (stop_det) begin
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
                ack_hold <= 1'b0;
                bit_cnt  <= '0;
            end else if (start_det) begin
                state    <= ST_DEV;
                sda_oe   <= 1'b0;
                ack_hold <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                case (state)
                    ST_DEV, ST_REG, ST_WDAT: begin
                        if (scl_rise) begin
                            rx_sh   <= rx_byte;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == BIT_LAST) begin
                                if (state == ST_DEV) begin
                                    if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                                        state   <= ST_DEV_ACK;
                                        rd_mode <= rx_byte[0];
                                        if (rx_byte[0]) begin
                                            rd_stb <= 1'b1;
                                            tx_sh  <= rd_byte;
                                        end
                                    end else begin
                                        state <= ST_IGNORE;
                                    end
                                end else if (state == ST_REG) begin
                                    reg_ptr <= rx_byte;
                                    state   <= ST_REG_ACK;
                                end else begin
                                    wr_data <= rx_byte;
                                    wr_stb  <= 1'b1;
                                    state   <= ST_WDAT_ACK;
                                end
                            end
                        end
                    end
                    ST_DEV_ACK, ST_REG_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            if (!ack_hold) begin
                                sda_oe   <= 1'b1;
                                ack_hold <= 1'b1;
                            end else begin
                                ack_hold <= 1'b0;
                                sda_oe   <= 1'b0;
                                if (state == ST_DEV_ACK && rd_mode) begin
                                    state  <= ST_RDAT;
                                    sda_oe <= ~tx_sh[BYTE_W-1];
                                end else if (state == ST_DEV_ACK) begin
                                    state <= ST_REG;
                                end else if (state == ST_REG_ACK) begin
                                    state <= ST_WDAT;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b1};
                            sda_oe <= ~tx_sh[BYTE_W-2];
                        end else if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == BIT_LAST) begin
                                state <= ST_RD_ACK;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                        end else if (scl_rise) begin
                            state <= sda_lvl ? ST_IDLE : ST_IGNORE;
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tws_reg_slave.sv
// Two-wire register slave top: ties bus sensing to the protocol
// controller and substitutes 0xFF for reads of unmapped registers.
// Assumes an external open-drain pad: sda_oe = 1 pulls data low.
module tws_reg_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b1001000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       reg_wr_en,
    output logic       reg_rd_en,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    input  logic [7:0] reg_rdata,
    input  logic       reg_hit
);
    localparam int BYTE_W = 8;

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic [BYTE_W-1:0] rd_byte;

    // Unmapped addresses read as all ones.
    assign rd_byte = reg_hit ? reg_rdata : '1;

    tws_bus_sense #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tws_proto_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .BYTE_W   (BYTE_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .sda_oe    (sda_oe),
        .wr_stb    (reg_wr_en),
        .rd_stb    (reg_rd_en),
        .reg_ptr   (reg_addr),
        .wr_data   (reg_wdata)
    );

endmodule

// File: rtl/tws_reg_slave_chk.sv
// Assertion checker for tws_reg_slave, attached with bind below.
// Assumes scl_i is observed directly at the block input.
module tws_reg_slave_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic reg_rd_en
);
    localparam int HI_LIM = SYNC_STAGES + 2;
    localparam int HI_W   = $clog2(HI_LIM + 1);

    logic [HI_W-1:0] hi_cnt;

    // Counts cycles the raw clock line has been high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !scl_i) begin
            hi_cnt <= '0;
        end else if (hi_cnt != HI_W'(HI_LIM)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R1: reset leaves the line released.
    a_r1_reset_release: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);

    // R5: write strobe lasts one cycle.
    a_r5_wr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R7: read strobe lasts one cycle.
    a_r7_rd_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    // R5 and R7: strobes never coincide.
    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    // R7: read strobe is raised while the host owns the line.
    a_r7_rd_line_free: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |-> !sda_oe);

    // R11: no change of the driven line while the clock stays high.
    a_r11_oe_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt == HI_W'(HI_LIM)) |-> $stable(sda_oe));

endmodule

bind tws_reg_slave tws_reg_slave_chk #(
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/tws_reg_slave_tb_top.sv
// Directed bench: host model on an open-drain bus plus a four-entry
// register bank; one task per scenario.
module tws_reg_slave_tb_top;
    localparam int Q = 10;  // system clocks per quarter bit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_host = 1'b1;
    logic       sda_oe;
    logic       reg_wr_en;
    logic       reg_rd_en;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       reg_hit;
    logic       sda_line;

    logic [7:0] bank [4];
    int         wr_cnt = 0;
    int         rd_cnt = 0;
    int         oe_cycles = 0;
    logic [7:0] last_wa = 8'h00;
    logic [7:0] last_wd = 8'h00;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    assign sda_line  = sda_host & ~sda_oe;
    assign reg_hit   = (reg_addr < 8'd4);
    assign reg_rdata = bank[reg_addr[1:0]];

    tws_reg_slave dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .reg_hit   (reg_hit)
    );

    // Register bank model and strobe/drive monitors.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
        end else begin
            if (reg_wr_en) begin
                if (reg_addr < 8'd4) bank[reg_addr[1:0]] <= reg_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wa <= reg_addr;
                last_wd <= reg_wdata;
            end
            if (reg_rd_en) rd_cnt <= rd_cnt + 1;
            if (sda_oe) oe_cycles <= oe_cycles + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_host = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_host = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_host = 1'b1; tick(2 * Q);
    endtask

    task automatic put_bit(input logic b);
        sda_host = b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_host = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    // Send a byte MSB first; ack = 1 when the slave pulled low.
    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    // Receive a byte, then send host_nack in the acknowledge slot.
    task automatic get_byte(output logic [7:0] v, input logic host_nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(host_nack);
    endtask

    localparam logic [7:0] DEV_W = 8'h90;
    localparam logic [7:0] DEV_R = 8'h91;

    task automatic t_reset();
        check("R1 sda_oe after reset", int'(sda_oe), 0);
        check("R1 write strobe after reset", int'(reg_wr_en), 0);
        check("R1 read strobe after reset", int'(reg_rd_en), 0);
    endtask

    task automatic do_write(input logic [7:0] ra, input logic [7:0] d,
                            output logic a0, output logic a1, output logic a2);
        bus_start();
        put_byte(DEV_W, a0);
        put_byte(ra, a1);
        put_byte(d, a2);
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] ra, output logic [7:0] v,
                           output logic a_dev);
        logic a;
        bus_start();
        put_byte(DEV_W, a);
        put_byte(ra, a);
        bus_start();
        put_byte(DEV_R, a_dev);
        get_byte(v, 1'b1);
        bus_stop();
    endtask

    task automatic t_write();
        logic a0, a1, a2;
        int w0 = wr_cnt;
        do_write(8'h02, 8'hA5, a0, a1, a2);
        check("R3 device address acknowledged", int'(a0), 1);
        check("R5 register address acknowledged", int'(a1), 1);
        check("R5 data acknowledged", int'(a2), 1);
        check("R5 one write strobe", wr_cnt - w0, 1);
        check("R5 write address", int'(last_wa), 8'h02);
        check("R5 write data", int'(last_wd), 8'hA5);
    endtask

    task automatic t_read();
        logic [7:0] v;
        logic a;
        int r0 = rd_cnt;
        do_read(8'h02, v, a);
        check("R7 read address acknowledged", int'(a), 1);
        check("R7 read data", int'(v), 8'hA5);
        check("R7 one read strobe", rd_cnt - r0, 1);
        check("R9 line released after NACK", int'(sda_oe), 0);
    endtask

    task automatic t_unmapped();
        logic [7:0] v;
        logic a;
        do_read(8'h40, v, a);
        check("R8 unmapped read value", int'(v), 8'hFF);
    endtask

    task automatic t_wrong_addr();
        logic a0, a1, a2;
        int w0 = wr_cnt;
        int o0 = oe_cycles;
        do_write(8'h01, 8'h77, a0, a1, a2);  // fine, sets a baseline
        w0 = wr_cnt;
        o0 = oe_cycles;
        bus_start();
        put_byte(8'h92, a0);   // address 1001001
        put_byte(8'h01, a1);
        put_byte(8'h11, a2);
        bus_stop();
        check("R4 wrong address not acknowledged", int'(a0), 0);
        check("R4 following bytes not acknowledged", int'(a1 | a2), 0);
        check("R4 line never driven", oe_cycles - o0, 0);
        check("R4 no write strobe", wr_cnt - w0, 0);
    endtask

    task automatic t_extra_byte();
        logic a0, a1, a2, a3;
        int w0 = wr_cnt;
        bus_start();
        put_byte(DEV_W, a0);
        put_byte(8'h03, a1);
        put_byte(8'h5A, a2);
        put_byte(8'hC3, a3);
        bus_stop();
        check("R6 second data byte not acknowledged", int'(a3), 0);
        check("R6 only one write", wr_cnt - w0, 1);
        check("R6 first data kept", int'(last_wd), 8'h5A);
    endtask

    task automatic t_stop_abort();
        logic a0, a1, a2;
        logic [7:0] v;
        int w0 = wr_cnt;
        bus_start();
        put_byte(DEV_W, a0);
        put_byte(8'h00, a1);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        check("R10 STOP inside data byte gives no write", wr_cnt - w0, 0);
        check("R10 line released after STOP", int'(sda_oe), 0);
        do_read(8'h00, v, a2);
        check("R2 transfer after abort acknowledged", int'(a2), 1);
        check("R10 register untouched by aborted write", int'(v), 8'h00);
    endtask

    task automatic t_start_abort();
        logic a0, a1, a2;
        logic [7:0] v;
        int w0 = wr_cnt;
        bus_start();
        put_byte(DEV_W, a0);
        put_byte(8'h01, a1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start();
        put_byte(DEV_W, a0);
        put_byte(8'h01, a1);
        put_byte(8'h3C, a2);
        bus_stop();
        check("R10 START inside data byte restarts", int'(a0 & a1 & a2), 1);
        check("R10 single write after restart", wr_cnt - w0, 1);
        do_read(8'h01, v, a0);
        check("R10 restarted write data", int'(v), 8'h3C);
    endtask

    task automatic t_host_ack();
        logic a0;
        logic [7:0] v;
        int o0;
        bus_start();
        put_byte(DEV_W, a0);
        put_byte(8'h02, a0);
        bus_start();
        put_byte(DEV_R, a0);
        get_byte(v, 1'b0);     // host acknowledges
        check("R9 data before host ACK", int'(v), 8'hA5);
        o0 = oe_cycles;
        get_byte(v, 1'b1);
        check("R9 no data after host ACK", int'(v), 8'hFF);
        check("R9 line stays released", oe_cycles - o0, 0);
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_write();
        t_read();
        t_unmapped();
        t_wrong_addr();
        t_extra_byte();
        t_stop_abort();
        t_start_abort();
        t_host_ack();
        tick(20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule